// File: doc/BRIEF.md
# Bang-Bang Frequency-Tracking Oscillator Drive

This block drives a resonant sense circuit from a numerically controlled oscillator. It keeps the drive locked so that the circuit's quadrature response lags the drive by a quarter period. A phase accumulator adds an unsigned frequency word every clock, and its top bit is the square drive output. Two asynchronous 1-bit observations come back from the circuit: a zero-crossing signal and a quadrature signal. Each is synchronized, and their XOR is registered as a one-bit phase error. Every clock the frequency word moves by one programmable step. It moves up when the registered error is 0 and down when it is 1.

A window of allowed frequency words is derived from a programmable nominal word and a span shift. This stops the loop from settling on a fraction or a multiple of the resonance. Below the window the loop is forced upward, and at or above its ceiling it is forced downward. The word is clamped at both edges, so it cannot wrap while the window is enabled. Software loads the nominal word, the step, the span shift and the enable through a small register write port.

Top module: `bbpll_core`

## Requirements
- R1: While reset is asserted, and at the first sample after it is released, the frequency word is 0 and the drive output is 0. With the window enabled, which is the reset value, the word rises by exactly one step on every clock after release while it is below the floor, whatever the phase inputs are.
- R2: With the window disabled, the word changes by the step each clock in a direction set by the synchronized inputs. If zero-crossing equals quadrature, the word goes up by the step. If they differ, it goes down by the step. The change follows a change on the inputs four clocks later: two synchronizer flops, one error register, then the word register.
- R3: With the window enabled, a registered below-floor flag forces an increase on every clock. The flag is set to 1 by reset and afterwards holds (word < floor) from the previous clock.
- R4: With the window enabled, a registered flag holding (word >= ceiling) forces a decrease. An increase never takes the word above the ceiling. Under a steady upward error the word settles within two steps below the ceiling, or at the ceiling.
- R5: With the window enabled, a decrease never takes a word that is at or above the floor below the floor. It stops exactly at the floor.
- R6: Register writes take effect on the clock edge where cfg_we is high. Address 0 holds the nominal word (reset 1000). Address 1 holds the step (reset 1). Address 2 holds the span shift S in bits 3:0 (reset 2). Address 3 holds the window enable in bit 0 (reset 1). The floor is N - (N >> S). The ceiling is N + (N >> S), saturated at 2^FW - 1.
- R7: With the window disabled, the word wraps modulo 2^FW under a constant error. With it enabled, the word never wraps and returns to within the window.
- R8: The phase accumulator (PW = 16 bits) adds the zero-extended word on every clock from a reset value of 0. drive_out is its most significant bit.
- R9: in_range is 1 exactly when floor < word < ceiling, judged combinationally from the current word and limits.
- R10: When the quadrature response lags by 90 degrees at a word inside the window, the word settles on average within 30 of that word. When the resonance lies below the window, the word rests at the floor. When it lies above the window, the word rests at the ceiling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select |
| cfg_wdata | input | FW (12) | Register write data |
| zc_in | input | 1 | Asynchronous zero-crossing observation |
| quad_in | input | 1 | Asynchronous quadrature observation |
| drive_out | output | 1 | Square drive, accumulator MSB |
| freq_word | output | FW (12) | Current frequency word |
| in_range | output | 1 | Word strictly inside the window |

## Verification
The hardest state to reach from the ports is a genuine quarter-period lock, because the quadrature input has to react to the frequency the block itself produces. The bench closes the loop with an ideal resonator model. The model keeps its own phase from the observed drive word and raises the quadrature bit after a lag that grows with the distance between that word and a chosen resonance, clamped between 0 and 180 degrees. Moving the resonance inside, below and above the window gives lock, floor clamping and ceiling clamping. Separate open-loop runs with constant inputs check the stepping, the wrap and the saturated ceiling.

// File: rtl/bbpll_pkg.sv
package bbpll_pkg;
  typedef enum logic [1:0] {
    CFG_NOMINAL = 2'd0,
    CFG_STEP    = 2'd1,
    CFG_SPAN    = 2'd2,
    CFG_CTRL    = 2'd3
  } cfg_sel_e;

  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } dir_e;
endpackage

// File: rtl/bbpll_sync.sv
module bbpll_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/bbpll_cfg.sv
module bbpll_cfg #(
  parameter int FW       = 12,
  parameter int SHW      = 4,
  parameter int NOM_RST  = 1000,
  parameter int STEP_RST = 1,
  parameter int SPAN_RST = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_addr,
  input  logic [FW-1:0] cfg_wdata,
  output logic [FW-1:0] lower,
  output logic [FW-1:0] upper,
  output logic [FW-1:0] step,
  output logic          lim_en
);
  import bbpll_pkg::*;

  localparam logic [FW-1:0] WORD_MAX = '1;

  // floor of the window: nominal minus a power-of-two fraction of itself
  function automatic logic [FW-1:0] floor_of(input logic [FW-1:0] nom,
                                              input logic [SHW-1:0] sh);
    return nom - (nom >> sh);
  endfunction

  // ceiling of the window, saturated at the largest word
  function automatic logic [FW-1:0] ceil_of(input logic [FW-1:0] nom,
                                             input logic [SHW-1:0] sh);
    logic [FW:0] s;
    s = {1'b0, nom} + {1'b0, (nom >> sh)};
    return s[FW] ? WORD_MAX : s[FW-1:0];
  endfunction

  logic [FW-1:0]  nom_q;
  logic [FW-1:0]  step_q;
  logic [SHW-1:0] span_q;
  logic           en_q;
  cfg_sel_e       sel;

  assign sel = cfg_sel_e'(cfg_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nom_q  <= FW'(NOM_RST);
      step_q <= FW'(STEP_RST);
      span_q <= SHW'(SPAN_RST);
      en_q   <= 1'b1;
    end else if (cfg_we) begin
      case (sel)
        CFG_NOMINAL: nom_q  <= cfg_wdata;
        CFG_STEP:    step_q <= cfg_wdata;
        CFG_SPAN:    span_q <= cfg_wdata[SHW-1:0];
        CFG_CTRL:    en_q   <= cfg_wdata[0];
        default:     ;
      endcase
    end
  end

  assign lower  = floor_of(nom_q, span_q);
  assign upper  = ceil_of(nom_q, span_q);
  assign step   = step_q;
  assign lim_en = en_q;
endmodule

// File: rtl/bbpll_steer.sv
module bbpll_steer #(
  parameter int FW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          zc_s,
  input  logic          qd_s,
  input  logic          lim_en,
  input  logic [FW-1:0] lower,
  input  logic [FW-1:0] upper,
  input  logic [FW-1:0] step,
  output logic [FW-1:0] freq_q,
  output logic          pd_q,
  output logic          below_q,
  output logic          above_q
);
  import bbpll_pkg::*;

  // named internal events, visible to the assertions below
  logic          force_up;
  logic          force_dn;
  dir_e          dir;
  logic [FW:0]   sum_w;
  logic [FW:0]   dif_w;
  logic          hit_hi;
  logic          hit_lo;
  logic [FW-1:0] up_val;
  logic [FW-1:0] dn_val;
  logic [FW-1:0] freq_d;

  assign force_up = lim_en & below_q;
  assign force_dn = lim_en & above_q & ~below_q;

  always_comb begin
    if (force_up)      dir = DIR_UP;
    else if (force_dn) dir = DIR_DOWN;
    else               dir = pd_q ? DIR_DOWN : DIR_UP;
  end

  assign sum_w  = {1'b0, freq_q} + {1'b0, step};
  assign dif_w  = {1'b0, freq_q} - {1'b0, step};
  assign hit_hi = lim_en && (sum_w > {1'b0, upper});
  assign hit_lo = lim_en && (dif_w[FW] || (dif_w[FW-1:0] < lower));
  // a clamp never moves the word the wrong way, and never wraps it
  assign up_val = hit_hi ? ((freq_q > upper) ? freq_q : upper) : sum_w[FW-1:0];
  assign dn_val = hit_lo ? ((freq_q < lower) ? freq_q : lower) : dif_w[FW-1:0];
  assign freq_d = (dir == DIR_UP) ? up_val : dn_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      freq_q  <= '0;
      pd_q    <= 1'b0;
      below_q <= 1'b1;
      above_q <= 1'b0;
    end else begin
      pd_q    <= zc_s ^ qd_s;
      below_q <= freq_q < lower;
      above_q <= freq_q >= upper;
      freq_q  <= freq_d;
    end
  end

  // R5: once at or above the floor the word stays there
  a_r5_floor_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_en && freq_q >= lower) |=> (freq_q >= $past(lower)));

  // R4: once at or below the ceiling the word stays there
  a_r4_ceiling_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_en && freq_q <= upper) |=> (freq_q <= $past(upper)));

  // R3: the below-floor flag never lets the word fall
  a_r3_forced_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_en && below_q) |=> (freq_q >= $past(freq_q)));

  // R4: the above-ceiling flag never lets the word rise
  a_r4_forced_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_en && above_q && !below_q) |=> (freq_q <= $past(freq_q)));

  // R2: with the window off and a nonzero step the word always moves
  a_r2_always_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (!lim_en && step != '0) |=> (freq_q != $past(freq_q)));
endmodule

// File: rtl/bbpll_nco.sv
module bbpll_nco #(
  parameter int FW = 12,
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [FW-1:0] freq,
  output logic          drive
);
  logic [PW-1:0] acc_q;
  logic [PW-1:0] inc_w;

  generate
    if (PW > FW) begin : g_pad
      assign inc_w = {{(PW-FW){1'b0}}, freq};
    end else begin : g_flat
      assign inc_w = freq;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_q + inc_w;
  end

  assign drive = acc_q[PW-1];

  // R8: the drive bit can only change while the word is nonzero
  a_r8_idle_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (freq == '0) |=> $stable(drive));
endmodule

// File: rtl/bbpll_core.sv
module bbpll_core #(
  parameter int FW       = 12,
  parameter int PW       = 16,
  parameter int SHW      = 4,
  parameter int SYNC_N   = 2,
  parameter int NOM_RST  = 1000,
  parameter int STEP_RST = 1,
  parameter int SPAN_RST = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_addr,
  input  logic [FW-1:0] cfg_wdata,
  input  logic          zc_in,
  input  logic          quad_in,
  output logic          drive_out,
  output logic [FW-1:0] freq_word,
  output logic          in_range
);
  localparam int NIN = 2;

  logic [NIN-1:0] raw_in;
  logic [NIN-1:0] sync_in;
  logic [FW-1:0]  lower, upper, step;
  logic           lim_en;
  logic [FW-1:0]  freq;
  logic           pd, below, above;

  assign raw_in = {quad_in, zc_in};

  generate
    for (genvar i = 0; i < NIN; i++) begin : g_sync
      bbpll_sync #(.STAGES(SYNC_N)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw_in[i]), .q(sync_in[i]));
    end
  endgenerate

  bbpll_cfg #(.FW(FW), .SHW(SHW), .NOM_RST(NOM_RST),
              .STEP_RST(STEP_RST), .SPAN_RST(SPAN_RST)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .lower(lower), .upper(upper), .step(step),
    .lim_en(lim_en));

  bbpll_steer #(.FW(FW)) u_steer (
    .clk(clk), .rst_n(rst_n), .zc_s(sync_in[0]), .qd_s(sync_in[1]),
    .lim_en(lim_en), .lower(lower), .upper(upper), .step(step),
    .freq_q(freq), .pd_q(pd), .below_q(below), .above_q(above));

  bbpll_nco #(.FW(FW), .PW(PW)) u_nco (
    .clk(clk), .rst_n(rst_n), .freq(freq), .drive(drive_out));

  assign freq_word = freq;
  assign in_range  = (freq > lower) && (freq < upper);

  // R9: the flag never claims range while the word sits on a limit
  a_r9_edge_out: assert property (@(posedge clk) disable iff (!rst_n)
    (freq == lower || freq == upper) |-> !in_range);

  // R1: the below-floor flag is set during the first clock after reset
  a_r1_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!rst_n) && lower != '0) |-> below);

  // R2: the registered error follows the synchronized inputs
  a_r2_pd_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_in[0] == sync_in[1]) |=> !pd);
endmodule

// File: tb/bbpll_core_test.sv
module bbpll_core_test;
  localparam int CLK_T = 10;
  localparam int FW = 12;
  localparam int WMAX = 4095;

  logic clk = 0;
  logic rst_n = 0;
  logic cfg_we = 0;
  logic [1:0] cfg_addr = 0;
  logic [FW-1:0] cfg_wdata = 0;
  logic zc_man = 0, qd_man = 0, res_zc = 0, res_qd = 0;
  logic use_res = 0;
  logic zc_in, quad_in;
  logic drive_out, in_range;
  logic [FW-1:0] freq_word;

  assign zc_in   = use_res ? res_zc : zc_man;
  assign quad_in = use_res ? res_qd : qd_man;

  always #(CLK_T/2) clk = ~clk;

  bbpll_core uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .zc_in(zc_in), .quad_in(quad_in),
    .drive_out(drive_out), .freq_word(freq_word), .in_range(in_range));

  int total = 0, bad = 0;
  int nom_m = 1000, sh_m = 2, step_m = 1, en_m = 1;
  int res_f0 = 1100;
  int dr_bad = 0, ir_bad = 0, win_bad = 0, wrap_cnt = 0;
  bit entered = 0;
  int prev_f = 0;
  int m_acc = 0;
  bit exp_q[$];

  function automatic int lo_of(int n, int s); return n - (n >> s); endfunction
  function automatic int hi_of(int n, int s);
    int h = n + (n >> s);
    return (h > WMAX) ? WMAX : h;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); #1;
    rst_n = 0;
    nom_m = 1000; sh_m = 2; step_m = 1; en_m = 1; entered = 0;
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
  endtask

  task automatic cfg_write(input int addr, input int data);
    @(negedge clk);
    cfg_we = 1; cfg_addr = addr[1:0]; cfg_wdata = data[FW-1:0];
    @(posedge clk); #1;
    case (addr)
      0: nom_m = data;
      1: step_m = data;
      2: sh_m = data & 15;
      default: en_m = data & 1;
    endcase
    entered = 0;
    @(negedge clk);
    cfg_we = 0;
  endtask

  // monitor / scoreboard: drive prediction queue, range flag, window, wrap, resonator
  always @(negedge clk) begin
    int f, lo, hi, ph, dly, e;
    f = freq_word; lo = lo_of(nom_m, sh_m); hi = hi_of(nom_m, sh_m);
    if (!rst_n) begin
      exp_q.delete(); exp_q.push_back(1'b0); m_acc = 0; prev_f = 0;
    end else begin
      e = exp_q.pop_front();
      if (drive_out !== e[0]) dr_bad++;                       // R8
      if (in_range !== ((f > lo) && (f < hi))) ir_bad++;       // R9
      if (en_m && f >= lo && f <= hi) entered = 1;
      if (en_m && entered && (f < lo || f > hi)) win_bad++;    // R4 R5
      if (f - prev_f > 2048 || prev_f - f > 2048) wrap_cnt++;  // R7
      prev_f = f;
      ph = 90 + (f - res_f0) / 2;
      if (ph < 0) ph = 0;
      if (ph > 180) ph = 180;
      dly = ph * 65536 / 360;
      res_zc = m_acc[15];
      res_qd = ((m_acc - dly + 65536) % 65536) >= 32768;
      m_acc = (m_acc + f) % 65536;
      exp_q.push_back(m_acc[15]);
    end
  end

  initial begin
    #(CLK_T * 190000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int fa, fb, mism, w0;
    longint sum;
    zc_man = 1; qd_man = 0;                 // constant error = 1
    @(negedge clk);
    check(freq_word == 0, "R1 reset word", freq_word, 0);
    check(drive_out == 0, "R1 reset drive", drive_out, 0);
    check(in_range == 0, "R9 reset range", in_range, 0);
    #1 rst_n = 1;
    // R1 R3: climb one step per clock despite the downward error
    mism = 0;
    for (int k = 1; k <= 740; k++) begin
      @(negedge clk);
      if (freq_word != k) mism++;
    end
    check(mism == 0, "R3 forced climb mismatches", mism, 0);
    repeat (60) @(negedge clk);
    check(freq_word == 750, "R5 rest at floor", freq_word, 750);
    check(in_range == 0, "R9 on floor", in_range, 0);
    zc_man = 0;                             // error = 0, push upward
    repeat (1000) @(negedge clk);
    check(freq_word >= 1248 && freq_word <= 1250, "R4 ceiling band", freq_word, 1250);

    // R2 R7 open loop
    cfg_write(3, 0);
    cfg_write(1, 3);
    repeat (8) @(negedge clk); fa = freq_word;
    repeat (10) @(negedge clk); fb = freq_word;
    check(((fb - fa) & WMAX) == 30, "R2 equal inputs step up", (fb - fa) & WMAX, 30);
    zc_man = 1;
    repeat (8) @(negedge clk); fa = freq_word;
    repeat (10) @(negedge clk); fb = freq_word;
    check(((fa - fb) & WMAX) == 30, "R2 unequal inputs step down", (fa - fb) & WMAX, 30);
    zc_man = 0;
    w0 = wrap_cnt;
    repeat (2000) @(negedge clk);
    check(wrap_cnt > w0, "R7 wrap without window", wrap_cnt - w0, 1);
    cfg_write(3, 1);
    w0 = wrap_cnt;
    repeat (3000) @(negedge clk);
    check(wrap_cnt == w0, "R7 no wrap with window", wrap_cnt - w0, 0);
    check(freq_word >= 1244 && freq_word <= 1250, "R7 back in window", freq_word, 1250);

    // R6 programmed limits
    do_reset();
    cfg_write(0, 2000);
    cfg_write(2, 3);
    cfg_write(1, 8);
    zc_man = 1;
    repeat (500) @(negedge clk);
    check(freq_word == 1750, "R6 programmed floor", freq_word, 1750);
    zc_man = 0;
    repeat (200) @(negedge clk);
    check(freq_word >= 2234 && freq_word <= 2250, "R6 programmed ceiling", freq_word, 2250);
    cfg_write(0, 4000);
    cfg_write(2, 1);
    w0 = wrap_cnt;
    repeat (400) @(negedge clk);
    check(freq_word >= 4079 && freq_word <= 4095, "R6 saturated ceiling", freq_word, 4095);
    check(wrap_cnt == w0, "R7 no wrap at saturated ceiling", wrap_cnt - w0, 0);

    // R10 closed loop lock inside the window
    res_f0 = 1100; use_res = 1;
    do_reset();
    repeat (20000) @(negedge clk);
    sum = 0;
    for (int k = 0; k < 8192; k++) begin @(negedge clk); sum += freq_word; end
    fa = int'(sum / 8192);
    check(fa >= 1070 && fa <= 1130, "R10 lock average", fa, 1100);
    check(in_range == 1, "R9 inside when locked", in_range, 1);

    // R10 R5 resonance below the window
    res_f0 = 500;
    do_reset();
    repeat (5000) @(negedge clk);
    check(freq_word == 750, "R10 low resonance held at floor", freq_word, 750);

    // R10 R4 resonance above the window
    res_f0 = 2000;
    do_reset();
    repeat (5000) @(negedge clk);
    check(freq_word >= 1248 && freq_word <= 1250, "R10 high resonance held at ceiling", freq_word, 1250);

    check(dr_bad == 0, "R8 drive scoreboard mismatches", dr_bad, 0);
    check(ir_bad == 0, "R9 range flag mismatches", ir_bad, 0);
    check(win_bad == 0, "R4 R5 window exits", win_bad, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule